// File: doc/BRIEF.md
# Programmable ROM Pin-Mode Model

This block is a synthesizable stand-in for a byte-wide, ultraviolet-erasable programmable ROM. It is meant to sit on the far side of a device programmer under test. From the control pins it works out the operating mode: the active-low chip select, output gate and program strobe, plus two digital flags. One flag means the programming supply is raised. The other means address pin 9 is raised to its high voltage. For that mode it drives, floats or writes the byte array.

A program pulse can only clear bits, and the array returns to all ones only through a bulk erase input. The write is taken when the program strobe rises. The block counts the clock cycles the strobe was held in program mode and flags a pulse that was too short or too long. With pin 9 raised, the block returns a two-byte identification code. The array depth is a parameter: the default keeps the model small, and the address pins stay at full width.

Top module: `eprom_model`

## Requirements
- R1: While reset is held, and until the first program commit, `pw_fault` is 0.
- R2: `mode` decodes the control pins with this encoding. 0 standby: ce_n high, supply not raised. 5 inhibit: ce_n high, supply raised. 6 identify: ce_n low, oe_n low, pin-9 flag set. 1 read: ce_n low, oe_n low, supply not raised. 4 verify: ce_n low, oe_n low, pgm_n high, supply raised. 3 program: ce_n low, oe_n high, pgm_n low, supply raised. 2 disable: every other case with ce_n low.
- R3: In read mode `dout_en` is 1 and `dout` shows the byte stored at the cell chosen by the low ARRAY_AW address bits.
- R4: In standby, disable and inhibit `dout_en` is 0 and `dout` is 0x00.
- R5: A program cycle commits when pgm_n is sampled high, provided the previous clock edge sampled program mode, ce_n is still low and the supply is still raised. The cell becomes its old value AND the data latched at that last program-mode edge. Bits can never go from 0 to 1 this way.
- R6: No cell changes in inhibit mode, or when ce_n rises in the same cycle as pgm_n.
- R7: In verify mode `dout_en` is 1 and `dout` shows the stored byte at the address.
- R8: In identify mode `dout_en` is 1 and `dout` is 0x1E when addr[0] is 0 and 0x05 when addr[0] is 1, whatever the array holds. This takes priority over read and verify.
- R9: `id_rest_low` is 1 only in identify mode with every address pin other than bits 0 and 9 at 0.
- R10: An `erase` sampled at a clock edge makes every cell read 0xFF from then on. It wins over a commit at the same edge.
- R11: `pw_fault` is 1 for the one cycle after a commit whose pulse lasted fewer than PW_MIN or more than PW_MAX program-mode clock edges. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_PINS | Address pins |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| din | input | 8 | Byte to be programmed |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hi | input | 1 | Address pin 9 at high voltage |
| erase | input | 1 | Bulk erase to all ones |
| dout | output | 8 | Data out, 0 when not driven |
| dout_en | output | 1 | Data pins driven |
| mode | output | 3 | Decoded mode, encoding in R2 |
| id_rest_low | output | 1 | Identify mode with unused address pins low |
| pw_fault | output | 1 | Last program pulse out of width range |

## Verification
A wrong cell value shows up on `dout` at the first read or verify of that address after the commit edge. A byte that gains a bit it should have lost points to a write that replaced the old value instead of ANDing with it. A wrong decode shows on `mode` and `dout_en` in the same cycle the pins change. A miscounted pulse shows on `pw_fault` one cycle after the commit edge, and the bench probes the counter exactly at both width limits.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  typedef enum logic [2:0] {
    M_STANDBY = 3'd0,
    M_READ    = 3'd1,
    M_DISABLE = 3'd2,
    M_PROGRAM = 3'd3,
    M_VERIFY  = 3'd4,
    M_INHIBIT = 3'd5,
    M_IDENT   = 3'd6
  } mode_e;

  localparam logic [7:0] MFR_CODE  = 8'h1E;
  localparam logic [7:0] DEV_CODE  = 8'h05;
  localparam logic [7:0] ERASED_B  = 8'hFF;
endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
  import eprom_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  pgm_n,
  input  logic  vpp_hi,
  input  logic  a9_hi,
  output mode_e mode
);
  always_comb begin
    if (ce_n) begin
      mode = vpp_hi ? M_INHIBIT : M_STANDBY;
    end else if (oe_n) begin
      mode = (vpp_hi && !pgm_n) ? M_PROGRAM : M_DISABLE;
    end else if (a9_hi) begin
      mode = M_IDENT;
    end else if (!vpp_hi) begin
      mode = M_READ;
    end else begin
      mode = pgm_n ? M_VERIFY : M_DISABLE;
    end
  end
endmodule

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl
  import eprom_pkg::*;
#(
  parameter int ARRAY_AW = 10,
  parameter int PW_MIN   = 95,
  parameter int PW_MAX   = 105
) (
  input  logic                clk,
  input  logic                rst_n,
  input  mode_e               mode,
  input  logic                ce_n,
  input  logic                pgm_n,
  input  logic                vpp_hi,
  input  logic [ARRAY_AW-1:0] addr,
  input  logic [7:0]          din,
  output logic                wr_en,
  output logic [ARRAY_AW-1:0] wr_addr,
  output logic [7:0]          wr_data,
  output logic                pw_fault
);
  localparam int CW = $clog2(PW_MAX + 2);
  localparam logic [CW-1:0] CNT_SAT = CW'(PW_MAX + 1);
  localparam logic [CW-1:0] CNT_MIN = CW'(PW_MIN);
  localparam logic [CW-1:0] CNT_MAX = CW'(PW_MAX);

  logic                in_prog_q, in_prog_d;
  logic [ARRAY_AW-1:0] lat_addr_q;
  logic [7:0]          lat_data_q;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic                fault_q, fault_d;
  logic                prog_now, commit;

  always_comb begin
    prog_now  = (mode == M_PROGRAM);
    in_prog_d = prog_now;
    commit    = in_prog_q && pgm_n && !ce_n && vpp_hi;
    cnt_d     = cnt_q;
    if (prog_now) begin
      if (!in_prog_q)          cnt_d = CW'(1);
      else if (cnt_q != CNT_SAT) cnt_d = cnt_q + CW'(1);
    end
    fault_d = commit && ((cnt_q < CNT_MIN) || (cnt_q > CNT_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_prog_q  <= 1'b0;
      cnt_q      <= '0;
      fault_q    <= 1'b0;
      lat_addr_q <= '0;
      lat_data_q <= '0;
    end else begin
      in_prog_q <= in_prog_d;
      cnt_q     <= cnt_d;
      fault_q   <= fault_d;
      if (prog_now) begin
        lat_addr_q <= addr;
        lat_data_q <= din;
      end
    end
  end

  assign wr_en    = commit;
  assign wr_addr  = lat_addr_q;
  assign wr_data  = lat_data_q;
  assign pw_fault = fault_q;

  a_r6_commit_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!ce_n && vpp_hi));
  a_r5_commit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $rose(pgm_n));
  a_r11_fault_follows_commit: assert property (@(posedge clk) disable iff (!rst_n)
    pw_fault |-> $past(wr_en));
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array
  import eprom_pkg::*;
#(
  parameter int ARRAY_AW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                erase,
  input  logic                wr_en,
  input  logic [ARRAY_AW-1:0] wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [ARRAY_AW-1:0] rd_addr,
  output logic [7:0]          rd_data
);
  localparam int DEPTH = 1 << ARRAY_AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED_B;
    end else if (wr_en) begin
      cells[wr_addr] <= cells[wr_addr] & wr_data;
    end
  end

  assign rd_data = cells[rd_addr];

  a_r10_erase_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (rd_data == ERASED_B));
  a_r5_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase) |=> ((cells[$past(wr_addr)] & ~$past(cells[wr_addr])) == 8'h00));
endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_pkg::*;
#(
  parameter int ADDR_PINS = 17,
  parameter int ARRAY_AW  = 10,
  parameter int PW_MIN    = 95,
  parameter int PW_MAX    = 105
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_PINS-1:0] addr,
  input  logic                 ce_n,
  input  logic                 oe_n,
  input  logic                 pgm_n,
  input  logic [7:0]           din,
  input  logic                 vpp_hi,
  input  logic                 a9_hi,
  input  logic                 erase,
  output logic [7:0]           dout,
  output logic                 dout_en,
  output logic [2:0]           mode,
  output logic                 id_rest_low,
  output logic                 pw_fault
);
  localparam int HV_PIN  = 9;
  localparam int SEL_PIN = 0;
  localparam logic [ADDR_PINS-1:0] REST_MASK =
    ~((ADDR_PINS'(1) << SEL_PIN) | (ADDR_PINS'(1) << HV_PIN));

  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  mode_e               mode_w;
  logic                wr_en;
  logic [ARRAY_AW-1:0] wr_addr;
  logic [7:0]          wr_data;
  logic [7:0]          rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  eprom_mode_decode u_dec (
    .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .a9_hi(a9_hi), .mode(mode_w)
  );

  eprom_prog_ctrl #(.ARRAY_AW(ARRAY_AW), .PW_MIN(PW_MIN), .PW_MAX(PW_MAX)) u_ctl (
    .clk(clk), .rst_n(rst_int_n), .mode(mode_w), .ce_n(ce_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .addr(addr[ARRAY_AW-1:0]), .din(din),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pw_fault(pw_fault)
  );

  eprom_cell_array #(.ARRAY_AW(ARRAY_AW)) u_arr (
    .clk(clk), .rst_n(rst_int_n), .erase(erase), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(addr[ARRAY_AW-1:0]), .rd_data(rd_data)
  );

  always_comb begin
    dout    = 8'h00;
    dout_en = 1'b0;
    unique case (mode_w)
      M_IDENT: begin
        dout_en = 1'b1;
        dout    = addr[SEL_PIN] ? DEV_CODE : MFR_CODE;
      end
      M_READ, M_VERIFY: begin
        dout_en = 1'b1;
        dout    = rd_data;
      end
      default: ;
    endcase
  end

  assign mode        = mode_w;
  assign id_rest_low = (mode_w == M_IDENT) && ((addr & REST_MASK) == '0);

  a_r4_select_high_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    ce_n |-> (!dout_en && dout == 8'h00));
  a_r8_ident_drives: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ce_n && !oe_n && a9_hi) |-> (dout_en && (dout == MFR_CODE || dout == DEV_CODE)));
endmodule

// File: tb/tb_eprom_model.sv
module tb_eprom_model;
  localparam int CLK_PERIOD = 10;
  localparam int AP = 17;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AP-1:0] addr;
  logic          ce_n, oe_n, pgm_n, vpp_hi, a9_hi, erase;
  logic [7:0]    din;
  logic [7:0]    dout;
  logic          dout_en, id_rest_low, pw_fault;
  logic [2:0]    mode;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] ref_mem [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  eprom_model dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .pgm_n(pgm_n), .din(din), .vpp_hi(vpp_hi), .a9_hi(a9_hi), .erase(erase),
    .dout(dout), .dout_en(dout_en), .mode(mode), .id_rest_low(id_rest_low),
    .pw_fault(pw_fault)
  );

  function automatic int exp_mode(bit ce, bit oe, bit pg, bit vp, bit a9);
    if (ce) return vp ? 5 : 0;
    if (oe) return (vp && !pg) ? 3 : 2;
    if (a9) return 6;
    if (!vp) return 1;
    return pg ? 4 : 2;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
    ce_n = 1; oe_n = 1; pgm_n = 1; vpp_hi = 0; a9_hi = 0; erase = 0;
  endtask

  task automatic do_erase();
    @(posedge clk); #1; erase = 1;
    @(posedge clk); #1; erase = 0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
  endtask

  task automatic do_read(logic [AP-1:0] a, string req);
    @(posedge clk); #1;
    ce_n = 0; oe_n = 0; pgm_n = 1; vpp_hi = 0; a9_hi = 0; addr = a;
    @(negedge clk);
    chk(req, mode, 1);
    chk(req, dout_en, 1);
    chk(req, dout, ref_mem[a[AW-1:0]]);
  endtask

  task automatic do_prog(logic [AW-1:0] a, logic [7:0] d, int n);
    bit f;
    @(posedge clk); #1;
    ce_n = 0; oe_n = 1; pgm_n = 0; vpp_hi = 1; a9_hi = 0; addr = AP'(a); din = d;
    repeat (n) @(posedge clk);
    #1; pgm_n = 1; din = ~d; addr = '0;
    @(posedge clk);
    @(negedge clk);
    ref_mem[a] = ref_mem[a] & d;
    f = (n < 95) || (n > 105);
    chk("R11 pulse width flag", pw_fault, f);
    idle();
    @(negedge clk);
    chk("R11 flag lasts one cycle", pw_fault, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; addr = '0; din = '0;
    ce_n = 1; oe_n = 1; pgm_n = 1; vpp_hi = 0; a9_hi = 0; erase = 0;
    repeat (3) @(negedge clk);
    chk("R1 fault low in reset", pw_fault, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 fault low after reset", pw_fault, 0);

    // R2 R4: every pin combination
    for (int c = 0; c < 32; c++) begin
      @(posedge clk); #1;
      {ce_n, oe_n, pgm_n, vpp_hi, a9_hi} = 5'(c);
      addr = AP'(3);
      @(negedge clk);
      chk("R2 mode decode", mode, exp_mode(c[4], c[3], c[2], c[1], c[0]));
      if (mode inside {3'd0, 3'd2, 3'd5}) begin
        chk("R4 outputs floated", dout_en, 0);
        chk("R4 data zero", dout, 0);
      end
    end

    do_erase();
    do_read(AP'(0), "R10 erased reads ones");
    do_read(AP'(DEPTH-1), "R10 erased reads ones top");

    // R5 AND behaviour and limits of pulse width
    do_prog(10'h005, 8'hA5, 100);
    do_read(AP'(5), "R5 programmed byte");
    do_prog(10'h005, 8'h5F, 95);
    do_read(AP'(5), "R5 bits only cleared");
    do_prog(10'h006, 8'h3C, 105);
    do_prog(10'h007, 8'hC3, 94);
    do_prog(10'h008, 8'h0F, 106);
    do_read(AP'(7), "R11 short pulse still writes");
    do_read(AP'(8), "R11 long pulse still writes");

    // R7 verify
    @(posedge clk); #1;
    ce_n = 0; oe_n = 0; pgm_n = 1; vpp_hi = 1; a9_hi = 0; addr = AP'(6);
    @(negedge clk);
    chk("R7 verify mode", mode, 4);
    chk("R7 verify enable", dout_en, 1);
    chk("R7 verify data", dout, ref_mem[6]);

    // R6 inhibit: strobe toggled with select high
    @(posedge clk); #1;
    ce_n = 1; oe_n = 1; pgm_n = 0; vpp_hi = 1; addr = AP'(9); din = 8'h00;
    repeat (100) @(posedge clk);
    #1; pgm_n = 1;
    @(posedge clk);
    idle();
    do_read(AP'(9), "R6 inhibit no write");

    // R6 select rises together with strobe
    @(posedge clk); #1;
    ce_n = 0; oe_n = 1; pgm_n = 0; vpp_hi = 1; addr = AP'(11); din = 8'h00;
    repeat (100) @(posedge clk);
    #1; pgm_n = 1; ce_n = 1;
    @(posedge clk);
    idle();
    do_read(AP'(11), "R6 aborted pulse no write");

    // R10 erase wins over commit at the same edge
    @(posedge clk); #1;
    ce_n = 0; oe_n = 1; pgm_n = 0; vpp_hi = 1; addr = AP'(12); din = 8'h00;
    repeat (100) @(posedge clk);
    #1; pgm_n = 1; erase = 1;
    @(posedge clk); #1; erase = 0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    idle();
    do_read(AP'(12), "R10 erase beats commit");
    do_read(AP'(5), "R10 erase restores ones");

    // R8 R9 identification independent of contents
    do_prog(10'h000, 8'h00, 100);
    do_prog(10'h001, 8'h00, 100);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      ce_n = 0; oe_n = 0; pgm_n = k[1]; vpp_hi = k[1]; a9_hi = 1;
      addr = AP'(k[0]) | ((k == 3) ? AP'(12'h402) : AP'(12'h200));
      @(negedge clk);
      chk("R8 identify mode", mode, 6);
      chk("R8 identify enable", dout_en, 1);
      chk("R8 identify code", dout, k[0] ? 8'h05 : 8'h1E);
      chk("R9 rest address flag", id_rest_low, (k == 3) ? 0 : 1);
    end
    idle();
    @(negedge clk);
    chk("R9 flag outside identify", id_rest_low, 0);
    do_read(AP'(0), "R3 read after identify");

    // R3 upper pins alias onto low cells
    do_read(AP'(17'h1_0000) | AP'(1), "R3 upper pins ignored by array");

    // random mix
    for (int it = 0; it < 160; it++) begin
      int op;
      op = int'($urandom % 20);
      if (op == 0) begin
        do_erase();
      end else if (op < 8) begin
        int n;
        n = ($urandom % 6 == 0) ? int'($urandom % 120) + 1 : 95 + int'($urandom % 11);
        do_prog(AW'($urandom), 8'($urandom), n);
      end else if (op < 14) begin
        do_read(AP'($urandom), "R3 random read");
      end else begin
        bit [4:0] p;
        p = 5'($urandom);
        @(posedge clk); #1;
        {ce_n, oe_n, pgm_n, vpp_hi, a9_hi} = p;
        addr = AP'($urandom);
        @(negedge clk);
        chk("R2 random decode", mode, exp_mode(p[4], p[3], p[2], p[1], p[0]));
        if (mode == 3'd4)
          chk("R7 random verify", dout, ref_mem[addr[AW-1:0]]);
        else if (mode == 3'd6)
          chk("R8 random identify", dout, addr[0] ? 8'h05 : 8'h1E);
        else if (mode != 3'd1)
          chk("R4 random float", dout_en, 0);
        idle();
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule